// File: doc/BRIEF.md
# UART Auto-Baud Detector

This block watches the conditioned receive line of a UART and works out how many reference clock cycles make up one bit. A clock-domain-local counter is started by the falling edge of a start bit and stopped by a later edge. The mode input decides which edge that is, and the measured interval is then scaled down to a single bit period. The scaled value is published on `divisor` with a one-cycle `done` strobe, so that a neighbouring receiver can load it as its baud divisor.

Four measurement patterns are available. Mode 00 times the start bit alone. Mode 01 runs from the start-bit fall to the next fall, which covers two bits on a character whose bit 0 is 1 and bit 1 is 0. Mode 10 expects the character 0x7F. Mode 11 expects 0x55. For both character modes the interval runs from the start-bit fall to the fall that opens data bit 7, which spans eight bits. A measurement that never completes, or that gives a divisor too small to be usable, raises `error` and leaves the old divisor in place.

The block makes a single attempt per enable. After a result, good or bad, it ignores the line until `enable` is dropped and raised again.

Top module: `autobaud_detect`

## Requirements
- R1: While reset is asserted, and just after it is released, `divisor` is 0 and both `done` and `error` are 0.
- R2: While `enable` is 0, no measurement runs. Dropping `enable` part-way through a measurement abandons it with no `done`, no `error` and no change to `divisor`. One clock after `enable` is seen low, `error` reads 0.
- R3: With `mode` = 2'b00, N is the number of clock edges from the edge that samples the start-bit fall to the edge that samples the next rise. The new `divisor` is N.
- R4: With `mode` = 2'b01, N is counted from the start-bit fall to the next falling edge. The new `divisor` is floor(N/2).
- R5: With `mode` = 2'b10 (character 0x7F, least significant bit first), N is counted from the start-bit fall to the next falling edge, which opens data bit 7. The new `divisor` is floor(N/8).
- R6: With `mode` = 2'b11 (character 0x55), N is counted from the start-bit fall to the fourth falling edge after it. The new `divisor` is floor(N/8).
- R7: A successful measurement updates `divisor` and raises `done` for exactly one cycle. Both are visible at the clock edge that follows the edge which sampled the stop edge.
- R8: After `done` or `error`, further line activity causes no `done`, no `error` change and no `divisor` change until `enable` has been low and high again.
- R9: If the counter reaches 2^CNT_W-1 without the stop edge, `error` is raised at the clock edge 2^CNT_W edges after the one that sampled the start-bit fall, and `divisor` is kept.
- R10: If the scaled value is below MIN_DIV, `error` is raised at the edge after the stop edge instead of `done`, and `divisor` is kept. `done` and `error` are never high together.
- R11: The mode is captured at the start-bit fall. Changes on `mode` during a measurement do not alter its stop edge or its scaling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Arms detection while high; a low level returns the block to idle |
| mode | input | 2 | Measurement pattern: 00 start bit, 01 fall-to-fall, 10 char 0x7F, 11 char 0x55 |
| rxLine | input | 1 | Conditioned receive line, idle high |
| divisor | output | CNT_W | Last valid per-bit period in clock cycles |
| done | output | 1 | One-cycle pulse on a valid measurement |
| error | output | 1 | Held high after a failed measurement until enable drops |

## Verification
The line is driven at falling clock edges. The bench logs the cycle stamp of every edge it drives and works out the expected stop edge from that log for the chosen mode. `done`, the new `divisor` and a range `error` are due one clock after the edge that samples the stop edge. A saturation `error` is due 2^CNT_W clocks after the edge that samples the start-bit fall. The bench samples at falling clock edges and compares the cycle stamp of the first result against those figures. It also counts `done` pulses over the whole frame, which catches extra pulses and any reaction to the edges that follow.

// File: rtl/abd_pkg.sv
package abd_pkg;

  typedef enum logic [1:0] {
    MODE_START  = 2'b00,
    MODE_FALL2  = 2'b01,
    MODE_CHAR7F = 2'b10,
    MODE_CHAR55 = 2'b11
  } abdMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       cntLoad;   // restart counter at 1
    logic       cntRun;    // advance counter
    logic       capture;   // load divisor from scaled count
    logic [1:0] shift;     // log2 of bits spanned by the interval
  } abdStrobe_t;

  // log2 of the number of bit times the measured interval covers
  function automatic logic [1:0] shiftFor(abdMode_e m);
    case (m)
      MODE_START:  return 2'd0;
      MODE_FALL2:  return 2'd1;
      default:     return 2'd3;
    endcase
  endfunction

  // zero-based index of the falling edge after the start fall that stops the count
  function automatic logic [2:0] stopFallIdx(abdMode_e m);
    case (m)
      MODE_CHAR55: return 3'd3;
      default:     return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/abd_edge.sv
module abd_edge (
  input  logic clk,
  input  logic rstN,
  input  logic rxLine,
  output logic fallSeen,
  output logic riseSeen
);

  logic rxPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxPrev <= 1'b1;
    else       rxPrev <= rxLine;
  end

  assign fallSeen = rxPrev & ~rxLine;
  assign riseSeen = ~rxPrev & rxLine;

endmodule

// File: rtl/abd_datapath.sv
module abd_datapath import abd_pkg::*; #(
  parameter int CNT_W   = 12,
  parameter int MIN_DIV = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  abdStrobe_t       strobe,
  output logic             cntSat,
  output logic             scaledOk,
  output logic [CNT_W-1:0] divisor
);

  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] MIN_DIV_C = CNT_W'(MIN_DIV);
  localparam int               NUM_SHIFT = 4;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] shifted [NUM_SHIFT];
  logic [CNT_W-1:0] scaled;

  // one right-shifted copy of the count per possible bit span
  for (genvar g = 0; g < NUM_SHIFT; g++) begin : gShift
    assign shifted[g] = count >> g;
  end

  assign scaled   = shifted[strobe.shift];
  assign scaledOk = (scaled >= MIN_DIV_C);
  assign cntSat   = (count == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.cntLoad) begin
      count <= CNT_W'(1);
    end else if (strobe.cntRun) begin
      count <= count + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divisor <= '0;
    end else if (strobe.capture) begin
      divisor <= scaled;
    end
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntRun |-> !cntSat);  // R9

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(divisor));  // R8

  AST_CAPTURE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (divisor >= MIN_DIV_C));  // R10

endmodule

// File: rtl/abd_control.sv
module abd_control import abd_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [1:0] mode,
  input  logic       fallSeen,
  input  logic       riseSeen,
  input  logic       cntSat,
  input  logic       scaledOk,
  output abdStrobe_t strobe,
  output logic       done,
  output logic       error
);

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_MEAS, ST_HOLD} state_e;

  state_e   state;
  abdMode_e modeReg;
  logic [2:0] fallCnt;
  logic stopHit;
  logic lastFall;

  always_comb begin
    lastFall = fallSeen && (fallCnt == stopFallIdx(modeReg));
    stopHit  = (modeReg == MODE_START) ? riseSeen : lastFall;
  end

  always_comb begin
    strobe.cntLoad = enable && (state == ST_ARMED) && fallSeen;
    strobe.cntRun  = enable && (state == ST_MEAS) && !stopHit && !cntSat;
    strobe.capture = enable && (state == ST_MEAS) && stopHit && scaledOk;
    strobe.shift   = shiftFor(modeReg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      modeReg <= MODE_START;
      fallCnt <= '0;
      done    <= 1'b0;
      error   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!enable) begin
        state <= ST_IDLE;
        error <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: state <= ST_ARMED;
          ST_ARMED: begin
            if (fallSeen) begin
              state   <= ST_MEAS;
              modeReg <= abdMode_e'(mode);
              fallCnt <= '0;
            end
          end
          ST_MEAS: begin
            if (stopHit) begin
              state <= ST_HOLD;
              if (scaledOk) done  <= 1'b1;
              else          error <= 1'b1;
            end else if (cntSat) begin
              state <= ST_HOLD;
              error <= 1'b1;
            end else if (fallSeen) begin
              fallCnt <= fallCnt + 3'd1;
            end
          end
          default: state <= ST_HOLD;
        endcase
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R7

  AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));  // R10

  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!done && !error));  // R2

  AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_HOLD) && $past(state == ST_HOLD)) |-> !done);  // R8

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_MEAS) && $past(state == ST_MEAS)) |-> $stable(modeReg));  // R11

endmodule

// File: rtl/autobaud_detect.sv
module autobaud_detect import abd_pkg::*; #(
  parameter int CNT_W   = 12,
  parameter int MIN_DIV = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [1:0]       mode,
  input  logic             rxLine,
  output logic [CNT_W-1:0] divisor,
  output logic             done,
  output logic             error
);

  abdStrobe_t strobe;
  logic fallSeen;
  logic riseSeen;
  logic cntSat;
  logic scaledOk;

  abd_edge u_edge (
    .clk      (clk),
    .rstN     (rstN),
    .rxLine   (rxLine),
    .fallSeen (fallSeen),
    .riseSeen (riseSeen)
  );

  abd_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .mode     (mode),
    .fallSeen (fallSeen),
    .riseSeen (riseSeen),
    .cntSat   (cntSat),
    .scaledOk (scaledOk),
    .strobe   (strobe),
    .done     (done),
    .error    (error)
  );

  abd_datapath #(.CNT_W(CNT_W), .MIN_DIV(MIN_DIV)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cntSat   (cntSat),
    .scaledOk (scaledOk),
    .divisor  (divisor)
  );

  AST_DONE_MIN: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (divisor >= CNT_W'(MIN_DIV)));  // R10

  AST_DIV_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(divisor) |-> done);  // R7

endmodule

// File: tb/test_autobaud_detect.sv
module test_autobaud_detect;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 12;
  localparam int MIN_DIV    = 4;
  localparam int SAT_SPAN   = 1 << CNT_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [1:0] mode = 2'b00;
  logic rxLine = 1'b1;
  logic [CNT_W-1:0] divisor;
  logic done;
  logic error;

  autobaud_detect #(.CNT_W(CNT_W), .MIN_DIV(MIN_DIV)) i_autobaud_detect (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(mode), .rxLine(rxLine),
    .divisor(divisor), .done(done), .error(error)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int doneCnt = 0;
  always @(negedge clk) if (done) doneCnt++;

  int nChecks = 0;
  int nFails = 0;
  int fallT[16];
  int riseT[16];
  int nFall = 0;
  int nRise = 0;

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setRx(input logic v);
    @(negedge clk);
    if (v != rxLine) begin
      if (!v) begin if (nFall < 16) fallT[nFall] = cyc; nFall++; end
      else    begin if (nRise < 16) riseT[nRise] = cyc; nRise++; end
    end
    rxLine = v;
  endtask

  task automatic holdRx(input logic v, input int n);
    for (int i = 0; i < n; i++) setRx(v);
  endtask

  task automatic sendFrame(input logic [7:0] b, input int p, input int extra);
    holdRx(1'b0, p + extra);
    for (int i = 0; i < 8; i++) holdRx(b[i], p);
    holdRx(1'b1, p);
  endtask

  task automatic waitResult(input int maxCyc, output int kind, output int tEvt);
    kind = 0;
    tEvt = 0;
    for (int i = 0; i < maxCyc; i++) begin
      @(negedge clk);
      if (done)  begin kind = 1; tEvt = cyc; break; end
      if (error) begin kind = 2; tEvt = cyc; break; end
    end
  endtask

  function automatic string modeTag(input int m);
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic int shiftOf(input int m);
    return (m == 0) ? 0 : (m == 1) ? 1 : 3;
  endfunction

  task automatic rearm(input int m);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    mode = 2'(m);
    enable = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic runMeas(input int m, input logic [7:0] b, input int p,
                         input int extra, input int swapMode);
    int kind, tEvt, stop, n, d0, prev;
    rearm(m);
    nFall = 0;
    nRise = 0;
    d0 = doneCnt;
    prev = int'(divisor);
    fork
      sendFrame(b, p, extra);
      waitResult(SAT_SPAN + 2000, kind, tEvt);
      if (swapMode >= 0) begin
        repeat (p / 2) @(negedge clk);
        mode = 2'(swapMode);
      end
    join
    stop = -1;
    case (m)
      0: if (nRise > 0) stop = riseT[0];
      1, 2: if (nFall > 1) stop = fallT[1];
      default: if (nFall > 4) stop = fallT[4];
    endcase
    n = stop - fallT[0];
    if (stop < 0 || n > SAT_SPAN - 1) begin
      check("R9 error kind", kind, 2);
      check("R9 error time", tEvt, fallT[0] + SAT_SPAN);
      check("R9 divisor kept", int'(divisor), prev);
      check("R9 no done", doneCnt - d0, 0);
    end else if ((n >> shiftOf(m)) < MIN_DIV) begin
      check("R10 error kind", kind, 2);
      check("R10 error time", tEvt, stop + 1);
      check("R10 divisor kept", int'(divisor), prev);
      check("R10 no done", doneCnt - d0, 0);
    end else begin
      check({modeTag(m), " done kind"}, kind, 1);
      check("R7 done time", tEvt, stop + 1);
      check({modeTag(m), " divisor"}, int'(divisor), n >> shiftOf(m));
      check("R7 R8 single done over frame", doneCnt - d0, 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    nFails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int d0;
    int p;
    int m;
    logic [7:0] b;
    void'($urandom(32'h5EED_0A1B));

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 divisor in reset", int'(divisor), 0);
    check("R1 done in reset", int'(done), 0);
    check("R1 error in reset", int'(error), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 divisor after reset", int'(divisor), 0);
    check("R1 flags after reset", int'({done, error}), 0);

    // R2 line activity while disabled
    d0 = doneCnt;
    sendFrame(8'h01, 8, 0);
    check("R2 no done while disabled", doneCnt - d0, 0);
    check("R2 divisor untouched while disabled", int'(divisor), 0);

    // directed mode cases
    runMeas(0, 8'hA5, 10, 0, -1);  // R3
    runMeas(0, 8'h00, 10, 0, -1);  // R3 long low run
    runMeas(0, 8'h01, 4, 0, -1);   // R3 at MIN_DIV
    runMeas(1, 8'h55, 20, 0, -1);  // R4
    runMeas(1, 8'h0D, 7, 1, -1);   // R4 odd interval
    runMeas(2, 8'h7F, 4, 0, -1);   // R5 at MIN_DIV
    runMeas(2, 8'h7F, 9, 5, -1);   // R5 truncation
    runMeas(3, 8'h55, 33, 0, -1);  // R6

    // R10 too small
    runMeas(0, 8'h01, 3, 0, -1);
    runMeas(3, 8'h55, 3, 0, -1);

    // R11 mode changed mid-measurement
    runMeas(1, 8'h55, 16, 0, 2);

    // R9 saturation: 0x7F never gives four falls
    runMeas(3, 8'h7F, 10, 0, -1);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R2 error cleared one clock after enable low", int'(error), 0);

    // R8 ignored after done
    runMeas(0, 8'h01, 12, 0, -1);
    d0 = doneCnt;
    sendFrame(8'h01, 30, 0);
    check("R8 no second done", doneCnt - d0, 0);
    check("R8 divisor kept", int'(divisor), 12);
    check("R8 no error", int'(error), 0);

    // R2 abort mid-measurement
    rearm(0);
    d0 = doneCnt;
    fork
      sendFrame(8'h01, 50, 0);
      begin repeat (20) @(negedge clk); enable = 1'b0; end
    join
    check("R2 abort no done", doneCnt - d0, 0);
    check("R2 abort no error", int'(error), 0);
    check("R2 abort divisor kept", int'(divisor), 12);

    // constrained random
    for (int it = 0; it < 30; it++) begin
      m = int'($urandom % 4);
      p = MIN_DIV + int'($urandom % 120);
      case (m)
        2: b = 8'h7F;
        3: b = 8'h55;
        1: b = (8'($urandom) | 8'h01) & 8'hFD;
        default: b = 8'($urandom);
      endcase
      runMeas(m, b, p, int'($urandom % 4), -1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule